// File: doc/BRIEF.md
# DRAM Self-Refresh Entry and Exit Controller

This block takes a DRAM array into its low-power self-refresh state when a sleep command arrives, and brings it back out when a wake command arrives. While it owns the memory bus it drives the row strobe, column strobe and write enable. It issues the refresh cycles that must immediately precede entry and follow exit. It tells the access sequencer through `ready` when the array may be used again.

Entry starts with a column-before-row refresh pattern: the column strobe falls first, then the row strobe, and the row strobe is then held low. The held pulse is never shorter than the self-refresh minimum. This keeps it clear of the forbidden band in which the device is changing mode. A wake command that arrives early is remembered and acted on once the minimum has passed. On exit the column strobe rises a little ahead of the row strobe. The row strobe then rests high for an extended exit precharge before refreshing resumes.

A mode input picks the refresh rule for the two boundaries. With evenly spread periodic refresh, one refresh cycle is issued on each side. With burst or row-only periodic refresh, every row is refreshed on each side. A busy flag from the periodic refresh timer holds back the start of entry until that timer's own cycle has finished.

Top module: `srx_ctrl`

## Requirements
- R1: After reset `ready` is 1, `bus_own` is 0, and `ras_n`, `cas_n` and `we_n` are all 1.
- R2: Every refresh cycle holds `cas_n` low for exactly T_CSR cycles before `ras_n` falls. `ras_n` then stays low for exactly T_RAS cycles. `we_n` is 1 whenever `bus_own` is 1.
- R3: With `mode_full` = 0 sampled at acceptance, exactly one refresh cycle is issued before the self-refresh pulse and exactly one after it.
- R4: With `mode_full` = 1 sampled at acceptance, exactly ROWS refresh cycles are issued before the self-refresh pulse and exactly ROWS after it.
- R5: The self-refresh pulse starts with `cas_n` low for T_CSR cycles before `ras_n` falls. `ras_n` stays low for at least T_SELF + T_CHS cycles. A wake pulse seen before the minimum is held, and the pulse then lasts exactly T_SELF + T_CHS cycles.
- R6: No low pulse on `ras_n` lasts between T_WIN_LO and T_SELF - 1 cycles inclusive.
- R7: On exit, `cas_n` rises exactly T_CHS cycles before `ras_n` rises.
- R8: After a self-refresh pulse, `ras_n` stays high for exactly T_RPS + T_CSR cycles before the first exit refresh cycle: the exit precharge followed by that cycle's column lead.
- R9: `ready` is 0 from the clock edge that samples `sleep_req` until the last exit refresh cycle has finished. While `ready` is 1 the strobes are high and `bus_own` is 0.
- R10: While `ref_busy` is 1 a sleep request is held pending: `bus_own` stays 0 and `ready` stays 0. Entry starts once `ref_busy` falls.
- R11: A change of `mode_full` after acceptance has no effect on the sequence. A `wake_req` while idle is discarded. A `sleep_req` while the sequence runs is discarded and starts no second sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | One-cycle command to enter self refresh |
| wake_req | input | 1 | One-cycle command to leave self refresh |
| mode_full | input | 1 | 0: one boundary refresh cycle; 1: all rows refreshed at each boundary |
| ref_busy | input | 1 | Periodic refresh timer is using the bus |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low (held high) |
| bus_own | output | 1 | Controller is driving the strobes |
| ready | output | 1 | Array available to the access sequencer |

## Verification
A sequencer stuck in a wrong state shows on the strobes within one refresh cycle. It appears as a column lead or row pulse of the wrong length, or as a row fall with the column strobe high. These are measured on every strobe edge. A refresh counter that is off by one shows as a wrong count of refresh cycles on either side of the long pulse, which is read out as soon as `ready` returns. A lost or stale wake flag changes the length of the long row pulse. The measured length is compared with the exact minimum for early wakes and must exceed it for late wakes. The exit precharge is timed from the row strobe's rise to its next fall.

// File: rtl/srx_pkg.sv
// Package: shared state encoding for the self-refresh controller.
package srx_pkg;

    // Sequencer states: R_* are refresh cycles, S_* the self-refresh pulse.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_R_CSR = 3'd1,
        ST_R_RAS = 3'd2,
        ST_R_RP  = 3'd3,
        ST_S_CSR = 3'd4,
        ST_S_HLD = 3'd5,
        ST_S_CHS = 3'd6,
        ST_S_RPS = 3'd7
    } srx_state_e;

endpackage

// File: rtl/srx_timer.sv
// Module: srx_timer
// Loadable down counter that times each sequencer state.
// Assumes: load_val is the state length minus one; done holds at zero.
module srx_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt;

    // Count down to zero after each load, then wait there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/srx_refcnt.sv
// Module: srx_refcnt
// Counts the refresh cycles that remain at one boundary (entry or exit).
// Assumes: load happens before the first decrement of each boundary.
module srx_refcnt #(
    parameter int ROWS = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic load_full,
    input  logic dec,
    output logic last
);

    localparam int CW = $clog2(ROWS + 1);
    localparam logic [CW-1:0] FULL = CW'(ROWS);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] cnt;

    // Load the boundary's quota; count one down per finished refresh cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_full ? FULL : ONE;
        else if (dec)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == ONE);

    AST_REF_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (cnt != '0)); // R4

endmodule

// File: rtl/srx_seq.sv
// Module: srx_seq
// State machine for entry refresh, self-refresh pulse, exit precharge and
// exit refresh. Decodes strobes from the state and keeps the wake and sleep
// pending flags.
// Assumes: all durations are at least one cycle; T_RAS < T_WIN_LO < T_SELF.
module srx_seq
    import srx_pkg::*;
#(
    parameter int T_CSR    = 2,
    parameter int T_RAS    = 15,
    parameter int T_RP     = 10,
    parameter int T_SELF   = 25000,
    parameter int T_WIN_LO = 2500,
    parameter int T_CHS    = 1,
    parameter int T_RPS    = 28,
    parameter int TW       = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sleep_req,
    input  logic          wake_req,
    input  logic          mode_full,
    input  logic          ref_busy,
    input  logic          tmr_done,
    input  logic          rc_last,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          rc_load,
    output logic          rc_full,
    output logic          rc_dec,
    output logic          ras_n,
    output logic          cas_n,
    output logic          we_n,
    output logic          bus_own,
    output logic          ready
);

    localparam logic [TW-1:0] L_CSR  = TW'(T_CSR - 1);
    localparam logic [TW-1:0] L_RAS  = TW'(T_RAS - 1);
    localparam logic [TW-1:0] L_RP   = TW'(T_RP - 1);
    localparam logic [TW-1:0] L_SELF = TW'(T_SELF - 1);
    localparam logic [TW-1:0] L_CHS  = TW'(T_CHS - 1);
    localparam logic [TW-1:0] L_RPS  = TW'(T_RPS - 1);
    localparam int RW = $clog2(T_SELF + 1);
    localparam int HW = $clog2(T_RPS + T_CSR + 1);

    srx_state_e state, state_n;
    logic       post_q;
    logic       mode_q;
    logic       sleep_pend;
    logic       wake_pend;
    logic       accept;
    logic       asleep_phase;
    logic       leave_hold;

    assign accept       = (state == ST_IDLE) && (sleep_req || sleep_pend) && !ref_busy;
    assign asleep_phase = !post_q && (state inside {ST_R_CSR, ST_R_RAS, ST_R_RP, ST_S_CSR, ST_S_HLD});
    assign leave_hold   = (state == ST_S_HLD) && tmr_done && (wake_pend || wake_req);

    // Next-state choice for the whole entry/exit sequence.
    always_comb begin
        state_n = state;
        case (state)
            ST_IDLE:  if (accept) state_n = ST_R_CSR;
            ST_R_CSR: if (tmr_done) state_n = ST_R_RAS;
            ST_R_RAS: if (tmr_done) state_n = ST_R_RP;
            ST_R_RP:  if (tmr_done) begin
                          if (!rc_last)    state_n = ST_R_CSR;
                          else if (post_q) state_n = ST_IDLE;
                          else             state_n = ST_S_CSR;
                      end
            ST_S_CSR: if (tmr_done) state_n = ST_S_HLD;
            ST_S_HLD: if (leave_hold) state_n = ST_S_CHS;
            ST_S_CHS: if (tmr_done) state_n = ST_S_RPS;
            ST_S_RPS: if (tmr_done) state_n = ST_R_CSR;
            default:  state_n = ST_IDLE;
        endcase
    end

    // Pick the length of the state about to be entered.
    always_comb begin
        case (state_n)
            ST_R_CSR, ST_S_CSR: tmr_val = L_CSR;
            ST_R_RAS:           tmr_val = L_RAS;
            ST_R_RP:            tmr_val = L_RP;
            ST_S_HLD:           tmr_val = L_SELF;
            ST_S_CHS:           tmr_val = L_CHS;
            ST_S_RPS:           tmr_val = L_RPS;
            default:            tmr_val = '0;
        endcase
    end

    assign tmr_load = (state_n != state);
    assign rc_load  = accept || ((state == ST_S_RPS) && tmr_done);
    assign rc_full  = accept ? mode_full : mode_q;
    assign rc_dec   = (state == ST_R_RP) && tmr_done;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Latch the refresh rule at acceptance so later changes are ignored.
    always_ff @(posedge clk) begin
        if (!rst_n)      mode_q <= 1'b0;
        else if (accept) mode_q <= mode_full;
    end

    // Mark the exit half of the sequence.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 post_q <= 1'b0;
        else if ((state == ST_S_RPS) && tmr_done)   post_q <= 1'b1;
        else if (state_n == ST_IDLE)                post_q <= 1'b0;
    end

    // Hold a sleep request while the periodic refresh timer has the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)                                              sleep_pend <= 1'b0;
        else if (accept)                                         sleep_pend <= 1'b0;
        else if (sleep_req && (state == ST_IDLE) && ref_busy)    sleep_pend <= 1'b1;
    end

    // Remember an early wake until the minimum pulse has elapsed.
    always_ff @(posedge clk) begin
        if (!rst_n)                         wake_pend <= 1'b0;
        else if (leave_hold)                wake_pend <= 1'b0;
        else if (wake_req && asleep_phase)  wake_pend <= 1'b1;
    end

    // Strobe decode from the current state.
    always_comb begin
        ras_n = !(state inside {ST_R_RAS, ST_S_HLD, ST_S_CHS});
        cas_n = !(state inside {ST_R_CSR, ST_R_RAS, ST_S_CSR, ST_S_HLD});
    end

    assign we_n    = 1'b1;
    assign bus_own = (state != ST_IDLE);
    assign ready   = (state == ST_IDLE) && !sleep_pend;

    // Observation counters for the timing assertions below.
    logic [RW-1:0] lo_run;
    logic [HW-1:0] hi_run;
    logic          self_last;

    // Length of the current row-strobe low run, saturating at the minimum.
    always_ff @(posedge clk) begin
        if (!rst_n || ras_n)          lo_run <= '0;
        else if (lo_run != RW'(T_SELF)) lo_run <= lo_run + 1'b1;
    end

    // Length of the current row-strobe high run, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !ras_n)                    hi_run <= '0;
        else if (hi_run != HW'(T_RPS + T_CSR))   hi_run <= hi_run + 1'b1;
    end

    // Flag that the last row pulse was a self-refresh pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)      self_last <= 1'b0;
        else if (!ras_n) self_last <= (lo_run >= RW'(T_SELF - 1));
    end

    AST_COL_BEFORE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n))); // R2
    AST_NO_FORBIDDEN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> ((lo_run < RW'(T_WIN_LO)) || (lo_run >= RW'(T_SELF)))); // R6
    AST_SELF_MIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cas_n) && !ras_n) |-> (lo_run >= RW'(T_SELF))); // R5
    AST_EXIT_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && self_last) |-> (hi_run >= HW'(T_RPS))); // R8
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (ras_n && cas_n && !bus_own)); // R9
    AST_BUSY_DEFERS: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_own && ref_busy) |=> !bus_own); // R10

endmodule

// File: rtl/srx_ctrl.sv
// Module: srx_ctrl (top)
// Self-refresh entry/exit controller: joins the sequencer, the state timer
// and the boundary refresh counter. Times are in clock cycles (250 MHz
// defaults: 100 us minimum pulse, 10 us forbidden-band start, 110 ns exit
// precharge).
// Assumes: sleep_req and wake_req are single-cycle pulses.
module srx_ctrl #(
    parameter int ROWS     = 2048,
    parameter int T_CSR    = 2,
    parameter int T_RAS    = 15,
    parameter int T_RP     = 10,
    parameter int T_SELF   = 25000,
    parameter int T_WIN_LO = 2500,
    parameter int T_CHS    = 1,
    parameter int T_RPS    = 28
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic wake_req,
    input  logic mode_full,
    input  logic ref_busy,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic bus_own,
    output logic ready
);

    localparam int TW = $clog2(T_SELF + T_RPS + T_RAS + T_RP + T_CSR + T_CHS + 1);

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_done;
    logic          rc_load;
    logic          rc_full;
    logic          rc_dec;
    logic          rc_last;

    srx_timer #(.W(TW)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    srx_refcnt #(.ROWS(ROWS)) refcnt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (rc_load),
        .load_full (rc_full),
        .dec       (rc_dec),
        .last      (rc_last)
    );

    srx_seq #(
        .T_CSR    (T_CSR),
        .T_RAS    (T_RAS),
        .T_RP     (T_RP),
        .T_SELF   (T_SELF),
        .T_WIN_LO (T_WIN_LO),
        .T_CHS    (T_CHS),
        .T_RPS    (T_RPS),
        .TW       (TW)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .wake_req  (wake_req),
        .mode_full (mode_full),
        .ref_busy  (ref_busy),
        .tmr_done  (tmr_done),
        .rc_last   (rc_last),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .rc_load   (rc_load),
        .rc_full   (rc_full),
        .rc_dec    (rc_dec),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .bus_own   (bus_own),
        .ready     (ready)
    );

endmodule

// File: tb/srx_ctrl_tb.sv
// Bench for srx_ctrl: a vector table of sleep/wake scenarios, then directed
// checks for reset, discarded commands and late wake.
module srx_ctrl_tb_top;

    localparam int ROWS = 8, T_CSR = 2, T_RAS = 4, T_RP = 3, T_SELF = 200;
    localparam int T_WIN_LO = 40, T_CHS = 2, T_RPS = 6;
    localparam int NV = 4;
    // Vector table: mode, wake delay, busy cycles, expected boundary count, exact-length flag.
    localparam int V_MODE [NV] = '{0, 1, 0, 1};
    localparam int V_WAKE [NV] = '{20, 20, 400, 5};
    localparam int V_BUSY [NV] = '{0, 0, 0, 6};
    localparam int V_NREF [NV] = '{1, ROWS, 1, ROWS};
    localparam int V_EXACT[NV] = '{1, 1, 0, 1};

    logic clk = 1'b0, rst_n = 1'b0;
    logic sleep_req = 1'b0, wake_req = 1'b0, mode_full = 1'b0, ref_busy = 1'b0;
    logic ras_n, cas_n, we_n, bus_own, ready;

    int n_chk = 0, n_err = 0, cyc = 0;
    bit done_flag = 0;

    // Monitor state
    int pre_cnt, post_cnt, self_len, self_chs, rps_len, lo_len, hi_len, lead, chs;
    int bad_lead, bad_len, bad_we;
    bit seen_self, rps_taken, prev_ras;

    always #2 clk = ~clk;

    srx_ctrl #(.ROWS(ROWS), .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP), .T_SELF(T_SELF),
               .T_WIN_LO(T_WIN_LO), .T_CHS(T_CHS), .T_RPS(T_RPS)) dut_i (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
        .mode_full(mode_full), .ref_busy(ref_busy), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .bus_own(bus_own), .ready(ready));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic mon_clear();
        pre_cnt = 0; post_cnt = 0; self_len = 0; self_chs = 0; rps_len = 0;
        bad_lead = 0; bad_len = 0; bad_we = 0; seen_self = 0; rps_taken = 0;
    endtask

    // Strobe monitor: measure pulse lengths at the falling clock edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_own && !we_n) bad_we++;
            if (prev_ras && !ras_n) begin
                if (lead != T_CSR) bad_lead++;
                if (seen_self && !rps_taken) begin rps_len = hi_len; rps_taken = 1; end
                lo_len = 0; chs = 0;
            end
            if (!prev_ras && ras_n) begin
                if (lo_len == T_RAS) begin
                    if (seen_self) post_cnt++; else pre_cnt++;
                end else if (lo_len >= T_SELF) begin
                    self_len = lo_len; self_chs = chs; seen_self = 1;
                end else bad_len++;
                hi_len = 0; lead = 0;
            end
            if (!ras_n) begin lo_len++; if (cas_n) chs++; end
            else begin hi_len++; if (!cas_n) lead++; end
            prev_ras = ras_n;
        end else begin
            prev_ras = 1; lo_len = 0; hi_len = 0; lead = 0; chs = 0;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done_flag) begin
            done_flag = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic wait_ready(output bit ok);
        ok = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (ready) begin ok = 1; break; end
        end
    endtask

    task automatic run_case(input int mode, input int wake_dly, input int busy,
                            input int nref, input int exact, input bit extra_sleep);
        bit ok;
        mon_clear();
        mode_full = mode[0];
        ref_busy = (busy > 0);
        @(negedge clk); sleep_req = 1;
        @(negedge clk); sleep_req = 0;
        check(ready == 0, "R9 ready drops after sleep", ready, 0);
        if (busy > 0) begin
            repeat (busy) @(negedge clk);
            check(bus_own == 0 && ready == 0, "R10 entry deferred while busy", bus_own, 0);
            ref_busy = 0;
        end
        repeat (2) @(negedge clk);
        mode_full = ~mode[0];                                   // R11 latched mode
        repeat (wake_dly) @(negedge clk);
        if (extra_sleep) begin sleep_req = 1; @(negedge clk); sleep_req = 0; end
        wake_req = 1; @(negedge clk); wake_req = 0;
        wait_ready(ok);
        check(ok, "R9 ready returns", ok, 1);
        check(pre_cnt == nref, "R3/R4 entry refresh count (R3 R4)", pre_cnt, nref);
        check(post_cnt == nref, "R3/R4 exit refresh count (R3 R4)", post_cnt, nref);
        if (exact) check(self_len == T_SELF + T_CHS, "R5 self pulse exact", self_len, T_SELF + T_CHS);
        else       check(self_len > T_SELF + T_CHS, "R5 self pulse extended", self_len, T_SELF + T_CHS + 1);
        check(self_chs == T_CHS, "R7 column rises ahead", self_chs, T_CHS);
        check(rps_len == T_RPS + T_CSR, "R8 exit precharge", rps_len, T_RPS + T_CSR);
        check(bad_lead == 0 && bad_len == 0, "R2 refresh cycle shape / R6 band", bad_lead + bad_len, 0);
        check(bad_we == 0, "R2 write enable high", bad_we, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(ready && !bus_own && ras_n && cas_n && we_n, "R1 reset state",
              {ready, bus_own, ras_n, cas_n, we_n}, 5'b10111);

        for (int v = 0; v < NV; v++)
            run_case(V_MODE[v], V_WAKE[v], V_BUSY[v], V_NREF[v], V_EXACT[v], 0);

        // R11: a wake while idle is discarded and must not shorten a later pulse.
        @(negedge clk); wake_req = 1; @(negedge clk); wake_req = 0;
        repeat (10) @(negedge clk);
        check(!bus_own && ready, "R11 idle wake ignored", bus_own, 0);
        run_case(0, 400, 0, 1, 0, 0);

        // R11: a sleep during the sequence starts no second sequence.
        run_case(0, 50, 0, 1, 1, 1);
        repeat (30) @(negedge clk);
        check(!bus_own && ready && ras_n, "R11 second sleep ignored", bus_own, 0);

        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule